// File: doc/BRIEF.md
# Quarter-Wave Programmed PWM Gate Generator

This block drives the four gates of one H-bridge from a small set of stored switching angles that describe a single quarter of the fundamental cycle. A phase accumulator advances by a programmable step on every clock. Each phase value is folded into a position inside one quarter-wave, and that position is compared with every stored angle. The parity of the number of angles already passed, together with the sign of the current half cycle, selects the bridge output state.

Two polarity modes are available. In the two-level mode the bridge only ever applies the full positive or full negative rail, so every transition is a full double-rail step, and the diagonal switches move in fixed pairs. In the three-level mode the bridge moves between one rail and zero. The rail it uses is set by the half cycle. Each leg is driven on its own, so every step spans a single rail. With N angles there are 2N notches or pulses per fundamental cycle. New angles and a new mode take effect only where the phase wraps, so a pattern is never mixed within one cycle. Solving for the angles and inserting dead-time belong to other blocks.

Top module: `ppwm_gate_gen`

## Requirements
- R1: While `rst` is high, at each rising edge the phase is cleared to 0, all four gates are driven off (`gate_out` = 4'b0000), and the current `angles_in` and `mode_sel` are taken as the active settings.
- R2: Out of reset the phase advances by `phase_step` modulo 2^PHASE_W on every clock. `gate_out` is registered and reflects the phase value held before that same edge, so it lags the phase by one clock.
- R3: The quarter-wave position is the low PHASE_W-2 phase bits when phase bit PHASE_W-2 is 0, and (2^(PHASE_W-2) - 1) minus those bits when it is 1. Phase bit PHASE_W-1 set marks the negative half cycle.
- R4: The crossing count is the number of active angles that are less than or equal to the quarter-wave position. Angle k occupies `angles_in[k*(PHASE_W-2) +: PHASE_W-2]`.
- R5: With `mode_sel` = 0 (two-level), the output is positive when (count is even) XOR (negative half) is 1, and negative otherwise. Positive is 4'b0011 and negative is 4'b1100, where bit0 = left upper, bit1 = right lower, bit2 = right upper, bit3 = left lower.
- R6: With `mode_sel` = 1 (three-level), an odd count applies the rail of the half cycle: 4'b0011 in the positive half and 4'b1100 in the negative half. An even count gives zero: 4'b0101 (both upper) in the positive half and 4'b1010 (both lower) in the negative half.
- R7: Apart from reset, new angles and a new mode are captured only at the edge where the phase addition carries out of PHASE_W bits. Until that edge the previous settings keep producing the output.
- R8: A leg never has both of its switches on (bits 0 and 3; bits 1 and 2). Out of reset exactly two gates are on.
- R9: In two-level mode the diagonal pairs are equal: bit0 equals bit1, and bit2 equals bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = two-level, 1 = three-level |
| angles_in | input | N_ANG*(PHASE_W-2) | Quarter-wave switching angles, packed |
| phase_step | input | PHASE_W | Phase increment per clock |
| gate_out | output | 4 | Gate drives, bit map as in R5 |

## Verification
A wrong phase or fold shows up as edges at the wrong positions in `gate_out` one clock after the faulty phase value, and the error repeats every quarter-wave. A wrong crossing parity or a swapped half-cycle sign flips the whole output state at once, and the fault appears in the first window of that quarter. Settings captured too early appear as edges from the new angles in the rest of the old cycle. A fault in the leg mapping produces a forbidden code that the per-cycle leg and pair checks report on the first clock after reset.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;

    typedef enum logic {
        PWM_TWO_LEVEL   = 1'b0,
        PWM_THREE_LEVEL = 1'b1
    } pwm_mode_e;

    // bit3 .. bit0
    typedef struct packed {
        logic lo_left;
        logic up_right;
        logic lo_right;
        logic up_left;
    } gate_t;

    localparam gate_t GATE_OFF    = 4'b0000;
    localparam gate_t GATE_POS    = 4'b0011;
    localparam gate_t GATE_NEG    = 4'b1100;
    localparam gate_t GATE_ZERO_H = 4'b0101;
    localparam gate_t GATE_ZERO_L = 4'b1010;

endpackage

// File: rtl/ppwm_phase_acc.sv
module ppwm_phase_acc #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase,
    output logic               wrap
);
    logic [PHASE_W:0] sum;

    always_comb begin
        sum  = {1'b0, phase} + {1'b0, step};
        wrap = sum[PHASE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= sum[PHASE_W-1:0];
    end

    // R2: phase moves by the step seen on the previous clock
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> phase == PHASE_W'($past(phase) + $past(step)));

endmodule

// File: rtl/ppwm_angle_bank.sv
module ppwm_angle_bank
    import ppwm_pkg::*;
#(
    parameter int N_ANG = 3,
    parameter int QW    = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wrap,
    input  logic                  mode_in,
    input  logic [N_ANG*QW-1:0]   ang_in,
    output pwm_mode_e             mode_q,
    output logic [N_ANG*QW-1:0]   ang_q
);
    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            ang_q  <= ang_in;
            mode_q <= pwm_mode_e'(mode_in);
        end
    end

    // R7: settings hold between cycle boundaries
    a_r7_hold_settings: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(ang_q) && $stable(mode_q)));

endmodule

// File: rtl/ppwm_level_decode.sv
module ppwm_level_decode
    import ppwm_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int N_ANG   = 3
) (
    input  logic [PHASE_W-1:0]          phase,
    input  logic [N_ANG*(PHASE_W-2)-1:0] ang,
    input  pwm_mode_e                   mode,
    output gate_t                       gate
);
    localparam int QW = PHASE_W - 2;

    logic [QW-1:0]    qpos;
    logic             neg_half;
    logic [N_ANG-1:0] crossed;
    logic             odd;

    always_comb begin
        neg_half = phase[PHASE_W-1];
        qpos     = phase[PHASE_W-2] ? ~phase[QW-1:0] : phase[QW-1:0];
    end

    for (genvar k = 0; k < N_ANG; k++) begin : g_cmp
        assign crossed[k] = (ang[k*QW +: QW] <= qpos);
    end

    always_comb begin
        odd = ^crossed;
        if (mode == PWM_TWO_LEVEL) begin
            gate = ((!odd) ^ neg_half) ? GATE_POS : GATE_NEG;
        end else if (odd) begin
            gate = neg_half ? GATE_NEG : GATE_POS;
        end else begin
            gate = neg_half ? GATE_ZERO_L : GATE_ZERO_H;
        end
    end

endmodule

// File: rtl/ppwm_gate_gen.sv
module ppwm_gate_gen
    import ppwm_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int N_ANG   = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mode_sel,
    input  logic [N_ANG*(PHASE_W-2)-1:0]  angles_in,
    input  logic [PHASE_W-1:0]            phase_step,
    output logic [3:0]                    gate_out
);
    localparam int QW = PHASE_W - 2;

    logic [PHASE_W-1:0]   phase;
    logic                 wrap;
    pwm_mode_e            mode_q;
    logic [N_ANG*QW-1:0]  ang_q;
    gate_t                gate_d;
    gate_t                gate_q;

    ppwm_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (phase_step),
        .phase (phase),
        .wrap  (wrap)
    );

    ppwm_angle_bank #(.N_ANG(N_ANG), .QW(QW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .mode_in (mode_sel),
        .ang_in  (angles_in),
        .mode_q  (mode_q),
        .ang_q   (ang_q)
    );

    ppwm_level_decode #(.PHASE_W(PHASE_W), .N_ANG(N_ANG)) u_dec (
        .phase (phase),
        .ang   (ang_q),
        .mode  (mode_q),
        .gate  (gate_d)
    );

    always_ff @(posedge clk) begin
        if (rst) gate_q <= GATE_OFF;
        else     gate_q <= gate_d;
    end

    assign gate_out = gate_q;

    // R1: reset drives every gate off
    a_r1_reset_off: assert property (@(posedge clk)
        rst |=> gate_q == GATE_OFF);

    // R8: no leg shorted
    a_r8_no_shoot: assert property (@(posedge clk) disable iff (rst)
        !(gate_q.up_left && gate_q.lo_left) && !(gate_q.up_right && gate_q.lo_right));

    // R8: two gates conduct after reset
    a_r8_two_on: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $countones(gate_q) == 2);

    // R9: diagonal pairs move together in two-level mode
    a_r9_diag_pairs: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PWM_TWO_LEVEL) |=>
            (gate_q.up_left == gate_q.lo_right) && (gate_q.up_right == gate_q.lo_left));

endmodule

// File: tb/ppwm_gate_gen_tb.sv
`timescale 1ns/1ps
module ppwm_gate_gen_tb;
    localparam int PW = 16;
    localparam int NA = 3;
    localparam int QW = PW - 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_sel = 1'b0;
    logic [NA*QW-1:0]  angles_in = '0;
    logic [PW-1:0]     phase_step = '0;
    logic [3:0]        gate_out;

    int n_checks = 0;
    int n_fail   = 0;

    ppwm_gate_gen #(.PHASE_W(PW), .N_ANG(NA)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .angles_in  (angles_in),
        .phase_step (phase_step),
        .gate_out   (gate_out)
    );

    always #2.5 clk = ~clk;

    // reference model state
    int    m_ph = 0;
    int    m_ang [NA];
    bit    m_mode = 0;
    bit    pending = 0;
    logic [3:0] exp_q [$];
    string      tag_q [$];
    bit         bip_q [$];
    bit         act_q [$];

    function automatic logic [3:0] ref_gate(int ph, int a0, int a1, int a2, bit md);
        int q, low, pos, cnt;
        bit neg;
        q   = (ph / 16384) % 4;
        low = ph % 16384;
        pos = (q == 1 || q == 3) ? (16383 - low) : low;
        neg = (ph >= 32768);
        cnt = 0;
        if (a0 <= pos) cnt++;
        if (a1 <= pos) cnt++;
        if (a2 <= pos) cnt++;
        if (!md) return ((((cnt % 2) == 0) != neg) ? 4'b0011 : 4'b1100);
        if ((cnt % 2) == 1) return (neg ? 4'b1100 : 4'b0011);
        return (neg ? 4'b1010 : 4'b0101);
    endfunction

    function automatic int ang_of(int k);
        return int'(angles_in[k*QW +: QW]);
    endfunction

    // driver-side model: one expected item per clock edge
    always @(posedge clk) begin
        int nx;
        if (rst) begin
            exp_q.push_back(4'b0000); tag_q.push_back("R1"); bip_q.push_back(0); act_q.push_back(0);
            m_ph = 0;
            for (int k = 0; k < NA; k++) m_ang[k] = ang_of(k);
            m_mode = mode_sel;
            pending = 0;
        end else begin
            exp_q.push_back(ref_gate(m_ph, m_ang[0], m_ang[1], m_ang[2], m_mode));
            tag_q.push_back(pending ? "R7" : (m_mode ? "R2 R3 R4 R6" : "R2 R3 R4 R5"));
            bip_q.push_back(!m_mode);
            act_q.push_back(1);
            nx = m_ph + int'(phase_step);
            if (nx >= 65536) begin
                for (int k = 0; k < NA; k++) m_ang[k] = ang_of(k);
                m_mode = mode_sel;
                pending = 0;
                nx = nx - 65536;
            end
            m_ph = nx;
        end
    end

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        logic [3:0] e;
        string t;
        bit b, a;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
            b = bip_q.pop_front(); a = act_q.pop_front();
            n_checks++;
            if (gate_out !== e) begin
                n_fail++;
                $display("FAIL %s: gate_out=%b expected=%b", t, gate_out, e);
            end
            if (a) begin
                n_checks++;
                if ((gate_out[0] && gate_out[3]) || (gate_out[1] && gate_out[2]) ||
                    ($countones(gate_out) != 2)) begin
                    n_fail++;
                    $display("FAIL R8: gate_out=%b expected two on, no leg shorted", gate_out);
                end
                if (b) begin
                    n_checks++;
                    if ((gate_out[0] != gate_out[1]) || (gate_out[2] != gate_out[3])) begin
                        n_fail++;
                        $display("FAIL R9: gate_out=%b expected equal diagonal pairs", gate_out);
                    end
                end
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_angles(int a0, int a1, int a2);
        angles_in = {QW'(a2), QW'(a1), QW'(a0)};
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state
        set_angles(1000, 5000, 12000);
        mode_sel = 0; phase_step = 16'd512;
        cycles(4);
        rst = 0;
        // R5: two-level pattern
        cycles(300);
        // R7: change settings mid-cycle, old ones must stay in force
        mode_sel = 1; set_angles(2000, 6000, 9000); pending = 1;
        cycles(300);
        // R6 with boundary angles and an odd step
        phase_step = 16'd4099; set_angles(0, 8191, 16383); pending = 1;
        cycles(400);
        // near-full step: a wrap on almost every clock
        phase_step = 16'hFFFF; mode_sel = 0; set_angles(300, 3000, 15000); pending = 1;
        cycles(60);
        // R1: reset in the middle of a run
        rst = 1; cycles(3); rst = 0;
        phase_step = 16'd64;
        cycles(1100);
        mode_sel = 1; pending = 1;
        cycles(1100);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule